// File: doc/BRIEF.md
# I2C Bus Clock Prescaler Search Engine

This block picks the settings for an I2C controller's bit-rate prescaler. Software or a boot sequencer gives it a divide ratio: the controller's input clock divided by the wanted bus speed. It also gives the input clock in kHz. From these the block works out the sample rate of the glitch filter. It then walks a fixed grid of prescaler candidates and returns the smallest effective divider that is strictly larger than the request. Because the chosen divider is above the request, the bus runs at or below the asked speed.

The grid has two indices. A multiplier index picks one of eight base values (10, 12, 14, 16, 18, 20, 24, 30). A shift index picks a power-of-two scale of 16 to 2048. The filter rate adds a correction term to each candidate. The winning pair of indices is packed into an 8-bit register code whose bits are not in index order. Either result can be forced through override inputs. A run starts with a strobe. The filter rate comes from an iterative divider, then one candidate is scored per clock. A one-cycle done pulse marks fresh results.

Top module: `i2c_div_search`

## Requirements
- R1: The ratio input is latched at start and clamped to 65535 when it does not fit in 16 bits, so any ratio above 65535 gives the same results as 65535.
- R2: Without a filter override, the filter output is floor(5 × clock_kHz / 100000). It is limited to 255, and a value of 0 becomes 1.
- R3: Each candidate's divider is B × (A + 2 × floor(3 × filter / B)), with B = 16 << s. eff_div_o is the smallest candidate strictly greater than the clamped ratio. Candidates are visited with A outermost in the order 10, 12, 14, 16, 18, 20, 24, 30 and s from 0 to 7 inside. On a tie the earlier candidate wins.
- R4: With g = multiplier index + 4 (4..11), the code output is (s << 2) | (g & 3) | ((g & 4) << 3). Bits 7:6 are therefore 0.
- R5: If no candidate exceeds the ratio, code_o is 0x31 and eff_div_o is all ones.
- R6: When flt_ovr_en is high at start, flt_ovr replaces the computed filter rate in both the search and flt_o. A value of 0 is still raised to 1.
- R7: When code_ovr_en is high at start, code_o is code_ovr. eff_div_o still reports the search result.
- R8: done_o pulses high for exactly one cycle. It is seen after the 65 + (KHZ_W + 3)th rising edge that follows the edge sampling start (92 with defaults). The result outputs change only in the cycle done_o is high.
- R9: A start strobe while a run is in progress is ignored. The run finishes with its own inputs and timing, and it produces no extra done pulse.
- R10: After reset, done_o is 0, code_o is 0x31, flt_o is 1 and eff_div_o is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (sampled only when idle) |
| ratio | input | RATIO_W | Input clock divided by requested bus speed |
| clk_khz | input | KHZ_W | Input clock frequency in kHz |
| flt_ovr_en | input | 1 | Use flt_ovr instead of the computed filter rate |
| flt_ovr | input | 8 | Forced filter sample rate |
| code_ovr_en | input | 1 | Report code_ovr instead of the searched code |
| code_ovr | input | 8 | Forced prescaler code |
| code_o | output | 8 | Packed prescaler code |
| flt_o | output | 8 | Filter sample rate used |
| eff_div_o | output | DIV_W | Effective divider of the winning candidate |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
On every cycle the bound checker enforces three things: the single-cycle done pulse, that outputs hold between pulses, and that the filter rate is never zero. At each pulse it also checks that a reported divider lies strictly above the latched ratio, that an unforced code keeps its top two bits clear, and that the fallback code goes with the all-ones divider. Only the bench's scenarios can show the rest: that the chosen divider is the minimum in visit order, that the filter quotient is exact, the override effects, the latency and the ignored busy strobe. It does this by sweeping ratios across several clock rates against an arithmetic model.

// File: rtl/i2cds_pkg.sv
package i2cds_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_SCAN} st_t;

   localparam logic [7:0] CODE_NONE = 8'h31;

   // base multiplier for each outer index, in visit order
   function automatic logic [4:0] mult_of(input logic [2:0] idx);
      case (idx)
         3'd0: mult_of = 5'd10;
         3'd1: mult_of = 5'd12;
         3'd2: mult_of = 5'd14;
         3'd3: mult_of = 5'd16;
         3'd4: mult_of = 5'd18;
         3'd5: mult_of = 5'd20;
         3'd6: mult_of = 5'd24;
         default: mult_of = 5'd30;
      endcase
   endfunction

   // scrambled register layout of the winning index pair
   function automatic logic [7:0] pack_code(input logic [2:0] idx, input logic [2:0] sh);
      logic [3:0] g;
      g = {1'b0, idx} + 4'd4;
      pack_code = {2'b00, g[2], sh, g[1:0]};
   endfunction
endpackage

// File: rtl/i2cds_rdiv.sv
module i2cds_rdiv #(
   parameter int NW = 27,
   parameter int DW = 17,
   parameter logic [DW-1:0] DEN = 17'd100000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [NW-1:0] num,
   output logic [NW-1:0] quo,
   output logic          fin
);
   localparam int CNT_W = $clog2(NW + 1);

   logic [NW-1:0]    sh;
   logic [DW-1:0]    rem;
   logic [CNT_W-1:0] cnt;
   logic             act;
   logic [DW:0]      trial;
   logic             fits;

   always_comb begin
      trial = {rem, sh[NW-1]};
      fits  = (trial >= {1'b0, DEN});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh  <= '0;
         rem <= '0;
         quo <= '0;
         cnt <= '0;
         act <= 1'b0;
         fin <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            sh  <= num;
            rem <= '0;
            quo <= '0;
            cnt <= CNT_W'(NW);
            act <= 1'b1;
         end else if (act) begin
            rem <= fits ? DW'(trial - {1'b0, DEN}) : trial[DW-1:0];
            quo <= {quo[NW-2:0], fits};
            sh  <= sh << 1;
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
               act <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/i2cds_cand.sv
module i2cds_cand
   import i2cds_pkg::*;
#(
   parameter int CW = 20
) (
   input  logic [2:0]    idx,
   input  logic [2:0]    sh,
   input  logic [7:0]    flt,
   output logic [CW-1:0] cand
);
   logic [9:0] tri_f;
   logic [3:0] amt;
   logic [9:0] corr;
   logic [7:0] base;

   always_comb begin
      tri_f = {2'b00, flt} + {1'b0, flt, 1'b0};
      amt   = {1'b0, sh} + 4'd4;
      corr  = tri_f >> amt;
      base  = {3'b000, mult_of(idx)} + {1'b0, corr[5:0], 1'b0};
      cand  = CW'(base) << amt;
   end
endmodule

// File: rtl/i2c_div_search.sv
module i2c_div_search
   import i2cds_pkg::*;
#(
   parameter int RATIO_W   = 32,
   parameter int KHZ_W     = 24,
   parameter int DIV_W     = 20,
   parameter bit CLAMP_FLT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [RATIO_W-1:0] ratio,
   input  logic [KHZ_W-1:0]   clk_khz,
   input  logic               flt_ovr_en,
   input  logic [7:0]         flt_ovr,
   input  logic               code_ovr_en,
   input  logic [7:0]         code_ovr,
   output logic [7:0]         code_o,
   output logic [7:0]         flt_o,
   output logic [DIV_W-1:0]   eff_div_o,
   output logic               done_o
);
   localparam int NUM_W = KHZ_W + 3;
   localparam int REQ_W = 16;
   localparam int DEN_W = 17;
   localparam logic [DEN_W-1:0] SCALE = DEN_W'(100000);

   if (DIV_W < 18) begin : g_bad_div_w
      $error("DIV_W must hold an 18-bit candidate");
   end
   if (RATIO_W < REQ_W) begin : g_bad_ratio_w
      $error("RATIO_W must be at least 16");
   end

   st_t              st;
   logic [REQ_W-1:0] req_q, req_sat;
   logic             fo_en_q, co_en_q;
   logic [7:0]       fo_q, co_q, flt_q;
   logic [2:0]       idx, sh;
   logic [DIV_W-1:0] best, cand, nbest;
   logic [7:0]       bcode, ncode, flt_calc, flt_pick;
   logic             go, div_fin, take, last;
   logic [NUM_W-1:0] num, quo;

   // ratio clamp: only needed when the ratio is wider than 16 bits
   if (RATIO_W > REQ_W) begin : g_sat
      assign req_sat = (ratio > RATIO_W'(16'hFFFF)) ? 16'hFFFF : ratio[REQ_W-1:0];
   end else begin : g_nosat
      assign req_sat = ratio[REQ_W-1:0];
   end

   // filter quotient: clamp to 8 bits or keep low byte
   if (CLAMP_FLT) begin : g_fclamp
      assign flt_calc = (quo > NUM_W'(255)) ? 8'd255 : quo[7:0];
   end else begin : g_fwrap
      assign flt_calc = quo[7:0];
   end

   assign go       = start && (st == ST_IDLE);
   assign num      = (NUM_W'(clk_khz) << 2) + NUM_W'(clk_khz);
   assign flt_pick = fo_en_q ? fo_q : flt_calc;

   i2cds_rdiv #(.NW(NUM_W), .DW(DEN_W), .DEN(SCALE)) u_div (
      .clk(clk), .rst_n(rst_n), .go(go), .num(num), .quo(quo), .fin(div_fin)
   );

   i2cds_cand #(.CW(DIV_W)) u_cand (
      .idx(idx), .sh(sh), .flt(flt_q), .cand(cand)
   );

   always_comb begin
      take  = (cand > DIV_W'(req_q)) && (cand < best);
      nbest = take ? cand : best;
      ncode = take ? pack_code(idx, sh) : bcode;
      last  = (idx == 3'd7) && (sh == 3'd7);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         req_q     <= '0;
         fo_en_q   <= 1'b0;
         fo_q      <= '0;
         co_en_q   <= 1'b0;
         co_q      <= '0;
         flt_q     <= 8'd1;
         idx       <= '0;
         sh        <= '0;
         best      <= '1;
         bcode     <= CODE_NONE;
         code_o    <= CODE_NONE;
         flt_o     <= 8'd1;
         eff_div_o <= '1;
         done_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (st)
            ST_IDLE: if (go) begin
               req_q   <= req_sat;
               fo_en_q <= flt_ovr_en;
               fo_q    <= flt_ovr;
               co_en_q <= code_ovr_en;
               co_q    <= code_ovr;
               st      <= ST_DIV;
            end
            ST_DIV: if (div_fin) begin
               flt_q <= (flt_pick == 8'd0) ? 8'd1 : flt_pick;
               idx   <= '0;
               sh    <= '0;
               best  <= '1;
               bcode <= CODE_NONE;
               st    <= ST_SCAN;
            end
            default: begin
               best  <= nbest;
               bcode <= ncode;
               sh    <= sh + 3'd1;
               if (sh == 3'd7) idx <= idx + 3'd1;
               if (last) begin
                  code_o    <= co_en_q ? co_q : ncode;
                  flt_o     <= flt_q;
                  eff_div_o <= nbest;
                  done_o    <= 1'b1;
                  st        <= ST_IDLE;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/i2cds_chk.sv
module i2cds_chk #(
   parameter int DIV_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done,
   input logic [7:0]       code,
   input logic [7:0]       flt,
   input logic [DIV_W-1:0] eff,
   input logic [15:0]      req,
   input logic             co_en
);
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(code) && $stable(flt) && $stable(eff)));

   p_flt_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      flt != 8'd0);

   p_above_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (eff != {DIV_W{1'b1}})) |-> (eff > DIV_W'(req)));

   p_fallback_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !co_en && (eff == {DIV_W{1'b1}})) |-> (code == 8'h31));

   p_code_layout_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !co_en) |-> (code[7:6] == 2'b00));
endmodule

bind i2c_div_search i2cds_chk #(.DIV_W(DIV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .done(done_o), .code(code_o), .flt(flt_o),
   .eff(eff_div_o), .req(req_q), .co_en(co_en_q)
);

// File: tb/i2c_div_search_test.sv
`timescale 1ns/1ps
module i2c_div_search_test;
   localparam int DIV_W = 20;
   localparam int LAT   = 24 + 3 + 65;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [31:0]      ratio = '0;
   logic [23:0]      clk_khz = '0;
   logic             flt_ovr_en = 1'b0, code_ovr_en = 1'b0;
   logic [7:0]       flt_ovr = '0, code_ovr = '0;
   logic [7:0]       code_o, flt_o;
   logic [DIV_W-1:0] eff_div_o;
   logic             done_o;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   i2c_div_search uut (
      .clk(clk), .rst_n(rst_n), .start(start), .ratio(ratio), .clk_khz(clk_khz),
      .flt_ovr_en(flt_ovr_en), .flt_ovr(flt_ovr), .code_ovr_en(code_ovr_en),
      .code_ovr(code_ovr), .code_o(code_o), .flt_o(flt_o),
      .eff_div_o(eff_div_o), .done_o(done_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000) begin
         $display("FAIL watchdog: actual=hung expected=finished");
         bad = bad + 1;
         total = total + 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string req, input string what, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // arithmetic model built from the requirements
   task automatic model(input longint r, input longint k, input bit fe, input int fv,
                        input bit ce, input int cv,
                        output int e_code, output int e_flt, output longint e_eff);
      longint sreq, f, best, c, b;
      int a, g;
      sreq = (r > 65535) ? 65535 : r;
      f = (5 * k) / 100000;
      if (f > 255) f = 255;
      if (fe) f = fv;
      if (f == 0) f = 1;
      best = (longint'(1) << DIV_W) - 1;
      e_code = 'h31;
      for (int ai = 0; ai < 8; ai++) begin
         case (ai)
            0: a = 10; 1: a = 12; 2: a = 14; 3: a = 16;
            4: a = 18; 5: a = 20; 6: a = 24; default: a = 30;
         endcase
         g = ai + 4;
         for (int s = 0; s < 8; s++) begin
            b = 16 << s;
            c = b * (a + ((3 * f) / b) * 2);
            if (c > sreq && c < best) begin
               best = c;
               e_code = (s << 2) | (g & 3) | ((g & 4) << 3);
            end
         end
      end
      if (ce) e_code = cv;
      e_flt = int'(f);
      e_eff = best;
   endtask

   task automatic run(input longint r, input longint k, input bit fe, input int fv,
                      input bit ce, input int cv, input string tag, input bit poke_busy);
      int n, e_code, e_flt, extra;
      longint e_eff;
      string rc, rf;
      model(r, k, fe, fv, ce, cv, e_code, e_flt, e_eff);
      @(negedge clk);
      ratio = r[31:0]; clk_khz = k[23:0];
      flt_ovr_en = fe; flt_ovr = fv[7:0]; code_ovr_en = ce; code_ovr = cv[7:0];
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!done_o && n < 300) begin
         @(posedge clk);
         @(negedge clk);
         n++;
         if (poke_busy && n == 30) begin
            // R9: strobe with different inputs mid-run
            ratio = 32'd5; clk_khz = 24'd400000; code_ovr_en = 1'b1; code_ovr = 8'hEE;
            start = 1'b1;
         end else if (poke_busy && n == 31) begin
            start = 1'b0;
         end
      end
      check(poke_busy ? "R9" : "R8", {tag, " latency"}, n, LAT);
      rc = ce ? "R7" : (e_eff == (longint'(1) << DIV_W) - 1) ? "R5" : "R4";
      rf = fe ? "R6" : "R2";
      check(poke_busy ? "R9" : rc, {tag, " code"}, code_o, e_code);
      check(poke_busy ? "R9" : rf, {tag, " flt"}, flt_o, e_flt);
      check(poke_busy ? "R9" : "R3", {tag, " eff"}, eff_div_o, e_eff);
      extra = 0;
      for (int i = 0; i < (poke_busy ? 120 : 1); i++) begin
         @(posedge clk);
         @(negedge clk);
         if (done_o) extra++;
      end
      check(poke_busy ? "R9" : "R8", {tag, " pulse width"}, extra, 0);
   endtask

   initial begin
      longint khz_list [6];
      khz_list = '{0, 19999, 20000, 333333, 1000000, 24'hFFFFFF};
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10", "reset done", done_o, 0);
      check("R10", "reset code", code_o, 'h31);
      check("R10", "reset flt", flt_o, 1);
      check("R10", "reset eff", eff_div_o, (1 << DIV_W) - 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: clamp of wide ratios, and fallback beyond the largest candidate
      run(65535, 20000, 0, 0, 0, 0, "R1 at limit", 0);
      run(70000, 20000, 0, 0, 0, 0, "R1 above limit", 0);
      run(32'hFFFFFFFF, 1000000, 0, 0, 0, 0, "R1 max ratio", 0);
      run(61439, 0, 0, 0, 0, 0, "R5 edge below max", 0);
      run(61440, 0, 0, 0, 0, 0, "R5 edge at max", 0);

      // R3: strictness and tie order around 320
      run(319, 0, 0, 0, 0, 0, "R3 tie 320", 0);
      run(320, 0, 0, 0, 0, 0, "R3 strict 320", 0);
      run(0, 0, 0, 0, 0, 0, "R3 zero ratio", 0);

      // R6 / R7: overrides
      run(1000, 1000000, 1, 0, 0, 0, "R6 zero override", 0);
      run(1000, 0, 1, 200, 0, 0, "R6 large override", 0);
      run(2500, 333333, 0, 0, 1, 'hA5, "R7 code override", 0);
      run(70000, 333333, 1, 77, 1, 'h00, "R7 override on fallback", 0);

      // R9: busy strobe ignored
      run(1234, 333333, 0, 0, 0, 0, "R9 busy strobe", 1);

      // sweep of ratios across filter rates (R2, R3, R4)
      for (int ki = 0; ki < 6; ki++) begin
         for (int i = 0; i < 48; i++) begin
            run(longint'(i * i * 27 + i), khz_list[ki], 0, 0, 0, 0, "R3 sweep", 0);
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule